// File: doc/BRIEF.md
# Memory Range Attribute Register File

This block holds a small, parameterised set of physical address ranges and attaches accessibility attributes to them. Each range is a pair of registers: an upper-bound register and a lower-bound register. The lower-bound register also carries the attribute bits. Each register has its own valid flag.

Software reaches the registers indirectly. It first writes an index register to choose one register of one pair. It then reads or writes a single data register, which acts as a window onto the chosen register. Bounds are kept at 64 KiB granularity. The register holds the physical address shifted right by four, so address bit 16 sits at register bit 12.

A combinational lookup port takes a physical address. It reports whether the address falls inside a fully valid range and, when it does, gives that range's attributes. When several ranges cover the same address, the lowest-numbered pair supplies the attributes.

Top module: `mem_range_attr`

## Requirements
- R1: After reset the index register is zero and every register of every pair reads as zero, so both valid flags of every pair are clear and every lookup misses.
- R2: A write to the index register is stored on the clock edge and is visible on the index readback port from the next cycle.
- R3: Index 2n selects the upper-bound register of pair n and index 2n+1 selects its lower-bound register. A data write changes only the selected register. When an index write and a data write happen in the same cycle, the data goes to the register chosen by the index value held before that edge.
- R4: Register format: bit 0 is the valid flag in both registers; bits 31:12 hold physical address bits 35:16; bits 4:1 of the lower-bound register hold the attributes. Every other bit, including bits 4:1 of the upper-bound register, reads as zero.
- R5: When the index is 2*NUM_PAIRS or larger, data writes have no effect on any register and the data register reads as zero.
- R6: A lookup hits pair n only when both of its valid flags are set and address bits 35:16 lie between the lower field and the upper field, both bounds included. The upper bound therefore covers through the last byte of its 64 KiB block.
- R7: When several pairs hit the same address, the lowest-numbered pair supplies the attributes.
- R8: On a miss the hit output is low and the attribute output is zero.
- R9: The data readback and the lookup outputs are combinational. They follow the current index and address in the same cycle, and they reflect a data write from the cycle after it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low asynchronous reset |
| idxWrEn | input | 1 | Index register write strobe |
| idxWrData | input | IDX_W | New index value |
| idxRdData | output | IDX_W | Current index value |
| dataWrEn | input | 1 | Data register write strobe |
| dataWrData | input | 32 | Value written to the selected register |
| dataRdData | output | 32 | Contents of the selected register |
| lkAddr | input | PA_W | Physical address to classify |
| lkHit | output | 1 | Address falls in a fully valid range |
| lkAttr | output | ATTR_W | Attributes of the winning range, zero on a miss |

## Verification
The hardest cases to reach are three kinds of overlap. The first is an address that several ranges cover while one of the lower-numbered ranges is only half valid. The second is a range made invalid again after it has won. The third is a data write in the same cycle as an index write. The stimulus builds them from the ports in order. It programs the lower half of a pair alone, then stacks ranges with different attributes over one another. It later clears a valid flag through the data register. It also issues index and data writes in the same cycle, then reads both the old and new targets. Bounds are probed exactly at the lower edge, one 64 KiB block below it, at the last byte of the upper block and one block above it.

// File: rtl/mem_range_attr_pkg.sv
package mem_range_attr_pkg;
  localparam int REG_W     = 32;
  localparam int BOUND_LSB = 16;  // granularity of the bounds: 64 KiB
  localparam int FIELD_LSB = 12;  // register bit that holds address bit 16
  localparam int VALID_BIT = 0;
  localparam int ATTR_LSB  = 1;

  // Strobes from the control to the datapath
  typedef struct packed {
    logic wrEn;     // data write to an implemented register
    logic inRange;  // index selects an implemented register
    logic selLo;    // 1: lower-bound register, 0: upper-bound register
  } mraStrobeT;
endpackage

// File: rtl/mem_range_attr_ctrl.sv
module mem_range_attr_ctrl
  import mem_range_attr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = 5,
  parameter int PAIR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWrEn,
  input  logic [IDX_W-1:0]  idxWrData,
  input  logic              dataWrEn,
  output logic [IDX_W-1:0]  idxQ,
  output mraStrobeT         strobe,
  output logic [PAIR_W-1:0] pairSel
);
  localparam int SLOTS = 2 * NUM_PAIRS;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)        idxQ <= '0;
    else if (idxWrEn) idxQ <= idxWrData;
  end

  // The data write uses the index held before the edge (R3)
  always_comb begin
    strobe.inRange = (32'(idxQ) < 32'(SLOTS));
    strobe.selLo   = idxQ[0];
    strobe.wrEn    = dataWrEn & strobe.inRange;
    pairSel        = PAIR_W'(idxQ >> 1);
  end
endmodule

// File: rtl/mem_range_attr_dp.sv
module mem_range_attr_dp
  import mem_range_attr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int PA_W      = 36,
  parameter int ATTR_W    = 4,
  parameter int PAIR_W    = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  mraStrobeT         strobe,
  input  logic [PAIR_W-1:0] pairSel,
  input  logic [REG_W-1:0]  wrData,
  output logic [REG_W-1:0]  rdData,
  input  logic [PA_W-1:0]   lkAddr,
  output logic              lkHit,
  output logic [ATTR_W-1:0] lkAttr
);
  localparam int BOUND_W = PA_W - BOUND_LSB;

  logic [BOUND_W-1:0] loBound [NUM_PAIRS];
  logic [BOUND_W-1:0] hiBound [NUM_PAIRS];
  logic [ATTR_W-1:0]  loAttr  [NUM_PAIRS];
  logic [NUM_PAIRS-1:0] loVld, hiVld, hitVec;
  logic [BOUND_W-1:0] lkBound;

  assign lkBound = lkAddr[PA_W-1:BOUND_LSB];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        loBound[p] <= '0;
        hiBound[p] <= '0;
        loAttr[p]  <= '0;
      end
      loVld <= '0;
      hiVld <= '0;
    end else if (strobe.wrEn) begin
      for (int p = 0; p < NUM_PAIRS; p++) begin
        if (pairSel == PAIR_W'(p)) begin
          if (strobe.selLo) begin
            loBound[p] <= wrData[FIELD_LSB +: BOUND_W];
            loAttr[p]  <= wrData[ATTR_LSB +: ATTR_W];
            loVld[p]   <= wrData[VALID_BIT];
          end else begin
            hiBound[p] <= wrData[FIELD_LSB +: BOUND_W];
            hiVld[p]   <= wrData[VALID_BIT];
          end
        end
      end
    end
  end

  // Per-pair inclusive range compare
  for (genvar p = 0; p < NUM_PAIRS; p++) begin : g_cmp
    assign hitVec[p] = loVld[p] & hiVld[p] &
                       (lkBound >= loBound[p]) & (lkBound <= hiBound[p]);
  end

  // Lowest-numbered pair wins: scan downward so the last assignment is the lowest
  always_comb begin
    lkHit  = 1'b0;
    lkAttr = '0;
    for (int p = NUM_PAIRS - 1; p >= 0; p--) begin
      if (hitVec[p]) begin
        lkHit  = 1'b1;
        lkAttr = loAttr[p];
      end
    end
  end

  // Readback of the selected register; unimplemented bits stay zero
  always_comb begin
    rdData = '0;
    for (int p = 0; p < NUM_PAIRS; p++) begin
      if (strobe.inRange && pairSel == PAIR_W'(p)) begin
        if (strobe.selLo) begin
          rdData[FIELD_LSB +: BOUND_W] = loBound[p];
          rdData[ATTR_LSB +: ATTR_W]   = loAttr[p];
          rdData[VALID_BIT]            = loVld[p];
        end else begin
          rdData[FIELD_LSB +: BOUND_W] = hiBound[p];
          rdData[VALID_BIT]            = hiVld[p];
        end
      end
    end
  end
endmodule

// File: rtl/mem_range_attr.sv
module mem_range_attr
  import mem_range_attr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = 5,
  parameter int PA_W      = 36,
  parameter int ATTR_W    = 4
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              idxWrEn,
  input  logic [IDX_W-1:0]  idxWrData,
  output logic [IDX_W-1:0]  idxRdData,
  input  logic              dataWrEn,
  input  logic [REG_W-1:0]  dataWrData,
  output logic [REG_W-1:0]  dataRdData,
  input  logic [PA_W-1:0]   lkAddr,
  output logic              lkHit,
  output logic [ATTR_W-1:0] lkAttr
);
  localparam int PAIR_W = (NUM_PAIRS > 1) ? $clog2(NUM_PAIRS) : 1;

  mraStrobeT         strobe;
  logic [PAIR_W-1:0] pairSel;

  mem_range_attr_ctrl #(
    .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W), .PAIR_W(PAIR_W)
  ) ctrl_i (
    .clk(clk), .rstN(rstN), .idxWrEn(idxWrEn), .idxWrData(idxWrData),
    .dataWrEn(dataWrEn), .idxQ(idxRdData), .strobe(strobe), .pairSel(pairSel)
  );

  mem_range_attr_dp #(
    .NUM_PAIRS(NUM_PAIRS), .PA_W(PA_W), .ATTR_W(ATTR_W), .PAIR_W(PAIR_W)
  ) dp_i (
    .clk(clk), .rstN(rstN), .strobe(strobe), .pairSel(pairSel),
    .wrData(dataWrData), .rdData(dataRdData), .lkAddr(lkAddr),
    .lkHit(lkHit), .lkAttr(lkAttr)
  );
endmodule

// File: rtl/mem_range_attr_chk.sv
module mem_range_attr_chk
  import mem_range_attr_pkg::*;
#(
  parameter int NUM_PAIRS = 8,
  parameter int IDX_W     = 5,
  parameter int PA_W      = 36,
  parameter int ATTR_W    = 4
) (
  input logic              clk,
  input logic              rstN,
  input logic              idxWrEn,
  input logic [IDX_W-1:0]  idxWrData,
  input logic [IDX_W-1:0]  idxRdData,
  input logic              dataWrEn,
  input logic [REG_W-1:0]  dataWrData,
  input logic [REG_W-1:0]  dataRdData,
  input logic [PA_W-1:0]   lkAddr,
  input logic              lkHit,
  input logic [ATTR_W-1:0] lkAttr
);
  localparam int BOUND_W = PA_W - BOUND_LSB;
  localparam logic [REG_W-1:0] ADDR_MASK = REG_W'(((64'd1 << BOUND_W) - 1) << FIELD_LSB);
  localparam logic [REG_W-1:0] ATTR_MASK = REG_W'(((64'd1 << ATTR_W) - 1) << ATTR_LSB);
  localparam logic [REG_W-1:0] VLD_MASK  = REG_W'(1) << VALID_BIT;

  logic idxOk;
  logic [REG_W-1:0] wrMask;
  assign idxOk  = 32'(idxRdData) < 32'(2 * NUM_PAIRS);
  assign wrMask = idxRdData[0] ? (ADDR_MASK | ATTR_MASK | VLD_MASK) : (ADDR_MASK | VLD_MASK);

  // R2: index capture
  a_r2_index_capture: assert property (@(posedge clk) disable iff (!rstN)
    idxWrEn |=> idxRdData == $past(idxWrData));

  // R4: written value reads back through the field mask
  a_r4_write_readback: assert property (@(posedge clk) disable iff (!rstN)
    (dataWrEn && !idxWrEn && idxOk) |=> dataRdData == ($past(dataWrData) & $past(wrMask)));

  // R5: unimplemented index reads zero
  a_r5_oob_reads_zero: assert property (@(posedge clk) disable iff (!rstN)
    !idxOk |-> dataRdData == '0);

  // R8: no attributes on a miss
  a_r8_miss_attr_zero: assert property (@(posedge clk) disable iff (!rstN)
    !lkHit |-> lkAttr == '0);

  // R9: without writes and with a steady address the outputs hold
  a_r9_hold_stable: assert property (@(posedge clk) disable iff (!rstN)
    (!idxWrEn && !dataWrEn) ##1 $stable(lkAddr) |->
      $stable(dataRdData) && $stable(lkHit) && $stable(lkAttr));
endmodule

bind mem_range_attr mem_range_attr_chk #(
  .NUM_PAIRS(NUM_PAIRS), .IDX_W(IDX_W), .PA_W(PA_W), .ATTR_W(ATTR_W)
) chk_i (.*);

// File: tb/mem_range_attr_tb_top.sv
module mem_range_attr_tb_top;
  localparam int NP = 8;
  localparam int IW = 5;
  localparam int AW = 36;
  localparam int TW = 4;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          idxWrEn = 1'b0;
  logic [IW-1:0] idxWrData = '0;
  logic [IW-1:0] idxRdData;
  logic          dataWrEn = 1'b0;
  logic [31:0]   dataWrData = '0;
  logic [31:0]   dataRdData;
  logic [AW-1:0] lkAddr = '0;
  logic          lkHit;
  logic [TW-1:0] lkAttr;

  always #2.5 clk = ~clk;  // 200 MHz

  mem_range_attr #(.NUM_PAIRS(NP), .IDX_W(IW), .PA_W(AW), .ATTR_W(TW)) dut_i (.*);

  int nCmp = 0;
  int nBad = 0;
  bit done = 1'b0;

  // Behavioural reference state
  logic [31:0] mLo [NP];
  logic [31:0] mHi [NP];
  int          mIdx;
  logic [AW-1:0] curLa = '0;

  function automatic logic [31:0] mRead(int idx);
    if (idx >= 2 * NP) return 32'h0;
    return idx[0] ? mLo[idx / 2] : mHi[idx / 2];
  endfunction

  function automatic logic [31:0] loVal(logic [AW-1:0] a, logic [TW-1:0] t);
    return {a[35:16], 7'b0, t, 1'b1};
  endfunction

  function automatic logic [31:0] hiVal(logic [AW-1:0] a);
    return {a[35:16], 11'b0, 1'b1};
  endfunction

  task automatic cmp(string tag, logic [31:0] act, logic [31:0] exp);
    nCmp++;
    if (act !== exp) begin
      nBad++;
      $display("FAIL %s: actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic cyc(bit iw, int iv, bit dw, logic [31:0] dv, logic [AW-1:0] la, string tag);
    logic          eHit;
    logic [TW-1:0] eAttr;
    @(negedge clk);
    idxWrEn = iw; idxWrData = IW'(iv);
    dataWrEn = dw; dataWrData = dv;
    lkAddr = la;
    #1;
    eHit = 1'b0; eAttr = '0;
    for (int p = NP - 1; p >= 0; p--) begin
      if (mLo[p][0] && mHi[p][0] && la[35:16] >= mLo[p][31:12] && la[35:16] <= mHi[p][31:12]) begin
        eHit = 1'b1; eAttr = mLo[p][4:1];
      end
    end
    cmp({tag, " R2 index"}, 32'(idxRdData), 32'(mIdx));
    cmp({tag, " R9 data readback"}, dataRdData, mRead(mIdx));
    cmp({tag, " R6 hit"}, 32'(lkHit), 32'(eHit));
    cmp({tag, " R7/R8 attr"}, 32'(lkAttr), 32'(eAttr));
    @(posedge clk);
    if (dw && mIdx < 2 * NP) begin
      if (mIdx % 2 == 1) mLo[mIdx / 2] = dv & 32'hFFFF_F01F;
      else               mHi[mIdx / 2] = dv & 32'hFFFF_F001;
    end
    if (iw) mIdx = iv;
  endtask

  task automatic setIdx(int i, string tag);
    cyc(1'b1, i, 1'b0, 32'h0, curLa, tag);
  endtask

  task automatic wrReg(int i, logic [31:0] v, string tag);
    setIdx(i, tag);
    cyc(1'b0, 0, 1'b1, v, curLa, tag);
  endtask

  task automatic look(logic [AW-1:0] a, string tag);
    curLa = a;
    cyc(1'b0, 0, 1'b0, 32'h0, a, tag);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      nBad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
      $finish;
    end
  end

  initial begin
    for (int p = 0; p < NP; p++) begin mLo[p] = 32'h0; mHi[p] = 32'h0; end
    mIdx = 0;
    repeat (3) @(posedge clk);
    #1 rstN = 1'b1;

    // R1: reset state, every slot reads zero and lookups miss
    for (int i = 0; i < 2 * NP + 2; i++) setIdx(i, "R1 reset read");
    look(36'h0_0000_0000, "R1 reset lookup");
    look(36'hF_FFFF_FFFF, "R1 reset lookup");

    // R6: half-valid pair does not hit
    wrReg(3, loVal(36'h0_0010_0000, 4'h5), "R6 lower only");
    look(36'h0_0015_0000, "R6 half valid");
    wrReg(2, hiVal(36'h0_001F_FFFF), "R3 upper of pair 1");
    look(36'h0_000F_FFFF, "R6 below lower");
    look(36'h0_0010_0000, "R6 at lower");
    look(36'h0_001F_FFFF, "R6 last byte of upper");
    look(36'h0_0020_0000, "R6 above upper");

    // R7: overlap, lowest pair wins
    wrReg(7, loVal(36'h0_0018_0000, 4'hA), "R3 pair 3 lower");
    wrReg(6, hiVal(36'h0_002F_FFFF), "R3 pair 3 upper");
    look(36'h0_0019_1234, "R7 pair1 over pair3");
    look(36'h0_0025_0000, "R7 pair3 alone");
    wrReg(1, loVal(36'h0, 4'h3), "R3 pair 0 lower");
    wrReg(0, hiVal(36'hF_FFFF_FFFF), "R3 pair 0 upper");
    look(36'h0_0019_0000, "R7 pair0 over all");
    look(36'h7_0000_0000, "R7 pair0 alone");

    // R5: out-of-range index ignored
    wrReg(16, 32'hFFFF_FFFF, "R5 oob write");
    wrReg(31, 32'hFFFF_FFFF, "R5 oob write");
    for (int i = 0; i < 2 * NP; i++) setIdx(i, "R5 regs unchanged");

    // R4: unimplemented bits read zero
    wrReg(5, 32'hFFFF_FFFF, "R4 lower all ones");
    setIdx(5, "R4 lower mask");
    wrReg(4, 32'hFFFF_FFFF, "R4 upper all ones");
    setIdx(4, "R4 upper mask");
    wrReg(1, 32'h0, "R6 clear pair0 valid");
    look(36'h0_0019_0000, "R7 pair1 after clear");
    look(36'h5_0000_0000, "R7 pair2 wide");

    // R3: same-cycle index and data write uses the old index
    setIdx(7, "R3 prep");
    cyc(1'b1, 9, 1'b1, loVal(36'h0_0018_0000, 4'h6), curLa, "R3 same cycle");
    setIdx(9, "R3 new target untouched");
    setIdx(7, "R3 old target written");
    look(36'h0_0025_0000, "R3 new attr");

    // R3: highest pair
    wrReg(15, loVal(36'h8_0000_0000, 4'h9), "R3 pair 7 lower");
    wrReg(14, hiVal(36'h8_0000_FFFF), "R3 pair 7 upper");
    wrReg(5, 32'h0, "R3 drop pair 2");
    look(36'h8_0000_FFFF, "R6 pair 7 single block");
    look(36'h8_0001_0000, "R8 past pair 7");

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nCmp, nBad);
    $finish;
  end
endmodule